// File: doc/BRIEF.md
# Soft-Start Two-Phase PWM Generator

The block drives a pair of pulse-width-modulated outputs at a fixed frequency derived from the system clock. With the defaults, a 50 MHz clock and a 333-count period give about 150 kHz. After reset the pulse width of the primary output starts at zero. It widens by one count at a fixed pace until it covers half the period, about 10 ms after reset, and then stays there. This soft start limits inrush in the stage being driven.

The second output has two forms, and a mode input chosen when reset is released selects between them. In the complementary form it is the inverse of the primary output, delayed one clock and gated so that the two are never high together. This leaves one clock of dead time after each primary falling edge. In the interleaved form it carries the same pulse width as the primary, shifted by half a period, for a two-phase converter. Each output takes a new width only at the start of its own period, so no pulse is ever cut short.

Top module: `pwm_softstart`

## Requirements
- R1: A period counter steps through 0 to PERIOD-1 and wraps to 0. The primary output is high in the clock after the counter is below the applied width, so it repeats every PERIOD clocks.
- R2: The target width is 0 after reset. It rises by exactly one every RAMP_STEP clocks: after t clocks it equals floor(t / RAMP_STEP), capped at DUTY_MAX.
- R3: Once the target reaches DUTY_MAX it never changes again, and `ramp_done` is high from that clock on.
- R4: Each output takes a new width only when its own period counter wraps. Over every full primary period, the number of high clocks equals the target value latched at the end of the previous period.
- R5: With mode 0 (complementary, `mode_sel` low when reset is released), the second output is high exactly when the primary output is low in both the present and the previous clock.
- R6: With mode 1 (interleaved), the second output follows a second period counter that starts at PERIOD/2. It has the same width sequence, latched at that counter's own wrap.
- R7: The mode is captured on the first clock edge after reset release. Later changes of `mode_sel` have no effect on either output.
- R8: Reset is asynchronous and active low. While it is asserted, both outputs and `ramp_done` are low, and the ramp restarts from zero after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = complementary pair, 1 = interleaved pair; captured after reset |
| pwm_a_o | output | 1 | Primary PWM output |
| pwm_b_o | output | 1 | Second PWM output (complementary or half-period shifted) |
| ramp_done_o | output | 1 | High once the width has reached DUTY_MAX |

## Verification
Some properties are checked on every cycle: counter range and wrap, the width moving only upward by one, the width freezing once complete, applied widths changing only at a wrap, the two outputs never being high together in complementary mode, and the captured mode never changing. Other behaviour needs the bench's scenarios. These are the exact timing of the ramp against elapsed clocks, the high-time of each whole period, the half-period placement of the interleaved output, and the indifference to `mode_sel` toggled after capture. The bench shows them with a model of the outputs as a function of clocks since reset, run over random-length runs with random mode toggling and mid-run resets.

// File: rtl/pwm_softstart_pkg.sv
package pwm_softstart_pkg;

  typedef enum logic {
    MODE_COMP  = 1'b0,
    MODE_INTER = 1'b1
  } pair_mode_e;

  // Next value of a modulo counter that runs 0 .. limit-1.
  function automatic int unsigned next_count(int unsigned cur, int unsigned limit);
    return (cur == limit - 1) ? 0 : cur + 1;
  endfunction

  // Comparator rule: output high while the count is below the width.
  function automatic logic below(int unsigned count, int unsigned width);
    return (count < width) ? 1'b1 : 1'b0;
  endfunction

  // Whether a step counter has reached the end of one ramp step.
  function automatic logic step_end(int unsigned cur, int unsigned step);
    return (cur == step - 1) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned PERIOD = 333,
  parameter int unsigned START  = 0,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] count_o,
  output logic          wrap_o
);
  import pwm_softstart_pkg::*;

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= CW'(START);
    else        count_q <= CW'(next_count(32'(count_q), PERIOD));
  end

  assign count_o = count_q;
  assign wrap_o  = (32'(count_q) == PERIOD - 1);

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_q) < PERIOD);

  a_r1_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (count_q == '0));

endmodule

// File: rtl/pwm_ramp_gen.sv
module pwm_ramp_gen #(
  parameter int unsigned DUTY_MAX  = 166,
  parameter int unsigned RAMP_STEP = 3012,
  parameter int unsigned DW        = $clog2(DUTY_MAX + 1),
  parameter int unsigned SW        = $clog2(RAMP_STEP)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] target_o,
  output logic          done_o
);
  import pwm_softstart_pkg::*;

  logic [SW-1:0] step_q;
  logic [DW-1:0] target_q;
  logic          at_top;
  logic          step_hit;

  assign at_top   = (32'(target_q) == DUTY_MAX);
  assign step_hit = step_end(32'(step_q), RAMP_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= '0;
      target_q <= '0;
    end else if (!at_top) begin
      if (step_hit) begin
        step_q   <= '0;
        target_q <= target_q + 1'b1;
      end else begin
        step_q   <= step_q + 1'b1;
      end
    end
  end

  assign target_o = target_q;
  assign done_o   = at_top;

  a_r2_up_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (target_q != $past(target_q)) |-> (target_q == $past(target_q) + 1'b1));

  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(target_q) <= DUTY_MAX);

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && $stable(target_q)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          wrap_i,
  input  logic [DW-1:0] target_i,
  output logic          cmp_o,
  output logic          pwm_o
);
  import pwm_softstart_pkg::*;

  logic [DW-1:0] width_q;
  logic          pwm_q;

  // Width is applied only at this channel's own period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      width_q <= '0;
    else if (wrap_i) width_q <= target_i;
  end

  assign cmp_o = below(32'(count_i), 32'(width_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= cmp_o;
  end

  assign pwm_o = pwm_q;

  a_r4_width_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(width_q));

endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart #(
  parameter int unsigned PERIOD    = 333,
  parameter int unsigned DUTY_MAX  = 166,
  parameter int unsigned RAMP_STEP = 3012
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  output logic pwm_a_o,
  output logic pwm_b_o,
  output logic ramp_done_o
);
  import pwm_softstart_pkg::*;

  localparam int unsigned CW       = $clog2(PERIOD);
  localparam int unsigned DW       = $clog2(DUTY_MAX + 1);
  localparam int unsigned HALF     = PERIOD / 2;
  localparam int unsigned NUM_CH   = 2;

  logic [DW-1:0] target;
  logic          ramp_done;
  logic [CW-1:0] ch_count [NUM_CH];
  logic          ch_wrap  [NUM_CH];
  logic          ch_cmp   [NUM_CH];
  logic          ch_pwm   [NUM_CH];

  pwm_ramp_gen #(
    .DUTY_MAX  (DUTY_MAX),
    .RAMP_STEP (RAMP_STEP),
    .DW        (DW)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .target_o (target),
    .done_o   (ramp_done)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_period_ctr #(
      .PERIOD (PERIOD),
      .START  (ch * HALF),
      .CW     (CW)
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_o (ch_count[ch]),
      .wrap_o  (ch_wrap[ch])
    );

    pwm_channel #(
      .CW (CW),
      .DW (DW)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_i  (ch_count[ch]),
      .wrap_i   (ch_wrap[ch]),
      .target_i (target),
      .cmp_o    (ch_cmp[ch]),
      .pwm_o    (ch_pwm[ch])
    );
  end

  // Mode capture on the first edge after reset release.
  logic       armed_q;
  pair_mode_e mode_q;
  pair_mode_e mode_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= MODE_COMP;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      mode_q  <= pair_mode_e'(mode_sel);
    end
  end

  assign mode_eff = armed_q ? mode_q : pair_mode_e'(mode_sel);

  // Complementary output: low while primary is high now or was high last clock.
  logic comp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) comp_q <= 1'b0;
    else        comp_q <= ~ch_pwm[0] & ~ch_cmp[0];
  end

  assign pwm_a_o     = ch_pwm[0];
  assign pwm_b_o     = (mode_eff == MODE_INTER) ? ch_pwm[1] : comp_q;
  assign ramp_done_o = ramp_done;

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == MODE_COMP) |-> !(pwm_a_o && pwm_b_o));

  a_r5_dead_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode_eff == MODE_COMP && $fell(pwm_a_o)) |-> !pwm_b_o);

  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(mode_q));

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!pwm_a_o && !pwm_b_o && !ramp_done_o));

endmodule

// File: tb/pwm_softstart_bench.sv
module pwm_softstart_bench;

  localparam int unsigned P = 21;
  localparam int unsigned M = 10;
  localparam int unsigned S = 7;
  localparam int unsigned H = P / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic pwm_a, pwm_b, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwm_softstart #(.PERIOD(P), .DUTY_MAX(M), .RAMP_STEP(S)) u_pwm_softstart (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .pwm_a_o     (pwm_a),
    .pwm_b_o     (pwm_b),
    .ramp_done_o (done)
  );

  // Expected model: everything as a function of edges since reset release.
  function automatic int tgt(int t);
    int v = t / int'(S);
    return (v > int'(M)) ? int'(M) : v;
  endfunction

  function automatic int cnt(int t, int off);
    return (off + t) % int'(P);
  endfunction

  function automatic int width(int t, int off);
    int w = t - cnt(t, off);
    return (w <= 0) ? 0 : tgt(w - 1);
  endfunction

  function automatic bit cmpv(int t, int off);
    return cnt(t, off) < width(t, off);
  endfunction

  function automatic bit exp_a(int t);
    return (t == 0) ? 1'b0 : cmpv(t - 1, 0);
  endfunction

  function automatic bit exp_b(int t, bit m);
    if (t == 0) return 1'b0;
    if (m) return cmpv(t - 1, int'(H));
    return !exp_a(t - 1) && !exp_a(t);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", {29'd0, pwm_a, pwm_b, done}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One run: mode fixed at release, optional toggling afterwards.
  task automatic run(bit m, int len, bit toggle);
    int hi_cnt = 0;
    mode_sel = m;
    do_reset();
    check("R8", {30'd0, pwm_a, done}, 0);
    for (int t = 1; t <= len; t++) begin
      @(posedge clk);
      @(negedge clk);
      check((t < int'(S * M)) ? "R2" : "R1", pwm_a, exp_a(t));
      check("R3", done, (t >= int'(S * M)) ? 1 : 0);
      if (toggle && t >= 2) check("R7", pwm_b, exp_b(t, m));
      else if (m) check("R6", pwm_b, exp_b(t, m));
      else check("R5", pwm_b, exp_b(t, m));
      hi_cnt += pwm_a;
      if (t % int'(P) == 0) begin
        int k = t / int'(P) - 1;
        check("R4", hi_cnt, (k == 0) ? 0 : tgt(k * int'(P) - 1));
        hi_cnt = 0;
      end
      if (toggle && t >= 2) mode_sel = 1'($urandom_range(0, 1));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #5;
    // Directed corners: both modes, long enough to pass the top of the ramp.
    run(1'b0, 8 * int'(P), 1'b0);
    run(1'b1, 8 * int'(P), 1'b0);
    // Mode input toggled after capture must be ignored.
    run(1'b0, 6 * int'(P), 1'b1);
    run(1'b1, 6 * int'(P), 1'b1);
    // Random runs, some cut short mid-ramp by a fresh reset.
    for (int r = 0; r < 12; r++) begin
      run(1'($urandom_range(0, 1)), int'($urandom_range(5, 260)),
          1'($urandom_range(0, 1)));
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule